// File: doc/BRIEF.md
# Doorbell Channel Window

This block is a single one-way doorbell window placed between a sending agent and a receiving agent. It holds a word of independent flags. The sender raises flags by writing ones. The receiver sees which flags are pending and hides the flags it does not care about with a mask. It retires a flag by writing a one to it. When the receiver retires a flag that was pending, the sender is told through a transfer-acknowledge status bit. That bit can raise the sender's interrupt.

Each side has its own simple register port: a write strobe, a word address and write data, with read data returned combinationally for the current address. Each side also drives one line that it contributes to a combined interrupt. The acknowledge status is held by a two-state machine. It has the states ACK_IDLE and ACK_RAISED. The transition RAISE (ACK_IDLE to ACK_RAISED) happens when a pending flag is retired. The transition DROP (ACK_RAISED to ACK_IDLE) happens when the sender writes the acknowledge-clear register and no new acknowledge arrives in the same cycle.

Top module: `dbw_window`

## Requirements
- R1: After reset the flag word, the acknowledge status, the acknowledge enable and both combined enables read 0, the receiver mask reads all ones, and both interrupt lines are low.
- R2: A sender write to address 1 ORs the written bits into the flag word. The word is readable at sender address 0 and at receiver address 0 from the next cycle.
- R3: A receiver write to address 2 clears the written flag bits from the next cycle.
- R4: Retiring a flag that was 1 sets the acknowledge status, which reads at bit 0 of sender address 2 from the next cycle. Writing a clear to a flag that was 0 does not set the acknowledge status.
- R5: Writing 1 to bit 0 of sender address 3 clears the acknowledge status. If a new acknowledge arrives in the same cycle, the status stays 1.
- R6: A receiver write to address 4 sets the written mask bits, and a write to address 5 clears them. If both happen in the same cycle, the set wins. The mask reads at receiver address 3.
- R7: Receiver address 1 reads the flag word ANDed with the inverse of the mask.
- R8: Bit 0 of sender address 4 is the acknowledge enable, and bit 0 of sender address 5 is the sender combined enable. Both are read/write. The sender interrupt equals acknowledge status AND acknowledge enable AND combined enable.
- R9: Bit 0 of receiver address 6 is the receiver combined enable, which is read/write. The receiver interrupt is high when that enable is 1 and the masked flags are nonzero.
- R10: Zero bits written to the set, clear, mask-set or mask-clear registers change nothing.
- R11: When a set and a clear hit the same flag bit in the same cycle, that bit ends up 1, and no acknowledge is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_wr | input | 1 | Sender write strobe |
| s_addr | input | 3 | Sender word address |
| s_wdata | input | FLAGS | Sender write data |
| s_rdata | output | FLAGS | Sender read data for s_addr |
| s_irq | output | 1 | Sender combined-interrupt contribution |
| r_wr | input | 1 | Receiver write strobe |
| r_addr | input | 3 | Receiver word address |
| r_wdata | input | FLAGS | Receiver write data |
| r_rdata | output | FLAGS | Receiver read data for r_addr |
| r_irq | output | 1 | Receiver combined-interrupt contribution |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a sender set and a receiver clear of the same flag. The second pair is a sender acknowledge-clear and a receiver retirement that raises a new acknowledge. Directed cycles drive each pair on both ports in one clock. The results are judged on the flag word, the acknowledge status and the sender interrupt one cycle later: the set must win and produce no acknowledge, and the new acknowledge must survive the clear. Random cycles drive both ports at once. They often clear flags that are currently pending, so these collisions also occur without being planned, and every register is compared against a model kept in the bench.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
    localparam int ADDR_W = 3;

    // sender register map
    localparam logic [ADDR_W-1:0] S_FLAGS   = 3'd0;
    localparam logic [ADDR_W-1:0] S_SET     = 3'd1;
    localparam logic [ADDR_W-1:0] S_ACK_ST  = 3'd2;
    localparam logic [ADDR_W-1:0] S_ACK_CLR = 3'd3;
    localparam logic [ADDR_W-1:0] S_ACK_EN  = 3'd4;
    localparam logic [ADDR_W-1:0] S_CMB_EN  = 3'd5;

    // receiver register map
    localparam logic [ADDR_W-1:0] R_FLAGS   = 3'd0;
    localparam logic [ADDR_W-1:0] R_VISIBLE = 3'd1;
    localparam logic [ADDR_W-1:0] R_CLEAR   = 3'd2;
    localparam logic [ADDR_W-1:0] R_MASK    = 3'd3;
    localparam logic [ADDR_W-1:0] R_MSET    = 3'd4;
    localparam logic [ADDR_W-1:0] R_MCLR    = 3'd5;
    localparam logic [ADDR_W-1:0] R_CMB_EN  = 3'd6;

    typedef enum logic {
        ACK_IDLE   = 1'b0,
        ACK_RAISED = 1'b1
    } ack_state_e;
endpackage

// File: rtl/dbw_flags.sv
module dbw_flags #(
    parameter int FLAGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLAGS-1:0] set_bits,
    input  logic [FLAGS-1:0] clr_bits,
    output logic [FLAGS-1:0] flags_q,
    output logic             ack_evt
);
    logic [FLAGS-1:0] retire;

    // a set on the same bit overrides its clear
    assign retire  = clr_bits & ~set_bits;
    assign ack_evt = |(flags_q & retire);

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~retire) | set_bits;
    end

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits) |=> ((flags_q & $past(set_bits)) == $past(set_bits)));

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|retire) |=> ((flags_q & $past(retire)) == '0));

    a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(flags_q));
endmodule

// File: rtl/dbw_mask.sv
module dbw_mask #(
    parameter int FLAGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLAGS-1:0] mset_bits,
    input  logic [FLAGS-1:0] mclr_bits,
    output logic [FLAGS-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q & ~mclr_bits) | mset_bits;
    end

    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|mset_bits) |=> ((mask_q & $past(mset_bits)) == $past(mset_bits)));

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mclr_bits & ~mset_bits)) |=> ((mask_q & $past(mclr_bits & ~mset_bits)) == '0));
endmodule

// File: rtl/dbw_ack_fsm.sv
module dbw_ack_fsm
    import dbw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_evt,
    input  logic ack_clr,
    output logic ack_st
);
    ack_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:   if (ack_evt) state_d = ACK_RAISED;                // RAISE
            ACK_RAISED: if (ack_clr && !ack_evt) state_d = ACK_IDLE;      // DROP
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_st = (state_q == ACK_RAISED);
    end

    a_r4_ack_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> ack_st);

    a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !ack_evt) |=> !ack_st);

    a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_st && !ack_clr) |=> ack_st);
endmodule

// File: rtl/dbw_window.sv
module dbw_window
    import dbw_pkg::*;
#(
    parameter int FLAGS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_wr,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [FLAGS-1:0]  s_wdata,
    output logic [FLAGS-1:0]  s_rdata,
    output logic              s_irq,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [FLAGS-1:0]  r_wdata,
    output logic [FLAGS-1:0]  r_rdata,
    output logic              r_irq
);
    localparam logic [FLAGS-1:0] ZERO = '0;

    logic [FLAGS-1:0] set_bits, clr_bits, mset_bits, mclr_bits;
    logic [FLAGS-1:0] flags_q, mask_q, visible;
    logic             ack_evt, ack_clr, ack_st;
    logic             s_ack_en_q, s_cmb_en_q, r_cmb_en_q;

    // write decode
    assign set_bits  = (s_wr && s_addr == S_SET)  ? s_wdata : ZERO;
    assign clr_bits  = (r_wr && r_addr == R_CLEAR) ? r_wdata : ZERO;
    assign mset_bits = (r_wr && r_addr == R_MSET) ? r_wdata : ZERO;
    assign mclr_bits = (r_wr && r_addr == R_MCLR) ? r_wdata : ZERO;
    assign ack_clr   = s_wr && s_addr == S_ACK_CLR && s_wdata[0];

    dbw_flags #(.FLAGS(FLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .clr_bits (clr_bits),
        .flags_q  (flags_q),
        .ack_evt  (ack_evt)
    );

    dbw_mask #(.FLAGS(FLAGS)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mset_bits (mset_bits),
        .mclr_bits (mclr_bits),
        .mask_q    (mask_q)
    );

    dbw_ack_fsm u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_evt (ack_evt),
        .ack_clr (ack_clr),
        .ack_st  (ack_st)
    );

    // enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ack_en_q <= 1'b0;
            s_cmb_en_q <= 1'b0;
            r_cmb_en_q <= 1'b0;
        end else begin
            if (s_wr && s_addr == S_ACK_EN) s_ack_en_q <= s_wdata[0];
            if (s_wr && s_addr == S_CMB_EN) s_cmb_en_q <= s_wdata[0];
            if (r_wr && r_addr == R_CMB_EN) r_cmb_en_q <= r_wdata[0];
        end
    end

    assign visible = flags_q & ~mask_q;
    assign s_irq   = ack_st & s_ack_en_q & s_cmb_en_q;
    assign r_irq   = r_cmb_en_q & (|visible);

    // read muxes
    always_comb begin
        s_rdata = ZERO;
        case (s_addr)
            S_FLAGS:  s_rdata = flags_q;
            S_ACK_ST: s_rdata[0] = ack_st;
            S_ACK_EN: s_rdata[0] = s_ack_en_q;
            S_CMB_EN: s_rdata[0] = s_cmb_en_q;
            default:  s_rdata = ZERO;
        endcase
    end

    always_comb begin
        r_rdata = ZERO;
        case (r_addr)
            R_FLAGS:   r_rdata = flags_q;
            R_VISIBLE: r_rdata = visible;
            R_MASK:    r_rdata = mask_q;
            R_CMB_EN:  r_rdata[0] = r_cmb_en_q;
            default:   r_rdata = ZERO;
        endcase
    end

    a_r8_s_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_irq |-> (ack_st && s_ack_en_q));

    a_r9_r_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        r_irq |-> ((flags_q & ~mask_q) != ZERO));

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_bits & clr_bits)) |=> ((flags_q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)));
endmodule

// File: tb/tb_dbw_window.sv
`timescale 1ns/1ps
module tb_dbw_window;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_wr, r_wr;
    logic [2:0]  s_addr, r_addr;
    logic [31:0] s_wdata, r_wdata, s_rdata, r_rdata;
    logic        s_irq, r_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_flags, m_mask;
    logic        m_ack, m_aen, m_sen, m_ren;

    always #5 clk = ~clk;

    dbw_window #(.FLAGS(32)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_irq(s_irq),
        .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq(r_irq)
    );

    task automatic check(string ctx, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    function automatic logic exp_sirq();
        return m_ack & m_aen & m_sen;
    endfunction

    function automatic logic exp_rirq();
        return m_ren & (|(m_flags & ~m_mask));
    endfunction

    task automatic model_step(logic sw, logic [2:0] sa, logic [31:0] sd,
                              logic rw, logic [2:0] ra, logic [31:0] rd);
        logic [31:0] set_v, clr_v, ms, mc;
        logic evt, aclr;
        set_v = (sw && sa == 3'd1) ? sd : 32'h0;
        clr_v = (rw && ra == 3'd2) ? rd : 32'h0;
        ms    = (rw && ra == 3'd4) ? rd : 32'h0;
        mc    = (rw && ra == 3'd5) ? rd : 32'h0;
        evt   = |(m_flags & clr_v & ~set_v);
        aclr  = sw && sa == 3'd3 && sd[0];
        m_flags = (m_flags & ~clr_v) | set_v;
        m_mask  = (m_mask & ~mc) | ms;
        if (evt) m_ack = 1'b1;
        else if (aclr) m_ack = 1'b0;
        if (sw && sa == 3'd4) m_aen = sd[0];
        if (sw && sa == 3'd5) m_sen = sd[0];
        if (rw && ra == 3'd6) m_ren = rd[0];
    endtask

    // drive one write cycle on both ports at negedge; model advances at posedge
    task automatic cyc(logic sw, logic [2:0] sa, logic [31:0] sd,
                       logic rw, logic [2:0] ra, logic [31:0] rd);
        @(negedge clk);
        s_wr = sw; s_addr = sa; s_wdata = sd;
        r_wr = rw; r_addr = ra; r_wdata = rd;
        @(posedge clk);
        model_step(sw, sa, sd, rw, ra, rd);
    endtask

    // read every register away from the edge and compare
    task automatic verify(string ctx);
        @(negedge clk);
        s_wr = 1'b0; r_wr = 1'b0;
        s_addr = 3'd0; r_addr = 3'd0; #1;
        check(ctx, "R2", s_rdata, m_flags);
        check(ctx, "R3", r_rdata, m_flags);
        check(ctx, "R8", {31'b0, s_irq}, {31'b0, exp_sirq()});
        check(ctx, "R9", {31'b0, r_irq}, {31'b0, exp_rirq()});
        s_addr = 3'd2; r_addr = 3'd1; #1;
        check(ctx, "R4", s_rdata, {31'b0, m_ack});
        check(ctx, "R7", r_rdata, m_flags & ~m_mask);
        s_addr = 3'd4; r_addr = 3'd3; #1;
        check(ctx, "R8", s_rdata, {31'b0, m_aen});
        check(ctx, "R6", r_rdata, m_mask);
        s_addr = 3'd5; r_addr = 3'd6; #1;
        check(ctx, "R8", s_rdata, {31'b0, m_sen});
        check(ctx, "R9", r_rdata, {31'b0, m_ren});
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog [timeout] actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        s_wr = 0; r_wr = 0; s_addr = 0; r_addr = 0; s_wdata = 0; r_wdata = 0;
        m_flags = 0; m_mask = '1; m_ack = 0; m_aen = 0; m_sen = 0; m_ren = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        verify("R1 reset state");

        // enables on
        cyc(1, 3'd4, 32'h1, 1, 3'd6, 32'h1);
        cyc(1, 3'd5, 32'h1, 1, 3'd5, 32'hFFFF_FFFF);
        verify("R8 R9 enables and unmask");

        // R2 set, then R4 clear of a zero flag gives no ack
        cyc(1, 3'd1, 32'h0000_0120, 0, 3'd0, 32'h0);
        verify("R2 set flags");
        cyc(0, 3'd0, 32'h0, 1, 3'd2, 32'h0000_0200);
        verify("R4 clear of idle flag no ack");

        // R11 set and clear on same pending bit
        cyc(1, 3'd1, 32'h0000_0020, 1, 3'd2, 32'h0000_0020);
        verify("R11 set/clear collision");

        // R4 real retirement raises ack
        cyc(0, 3'd0, 32'h0, 1, 3'd2, 32'h0000_0020);
        verify("R4 retire raises ack");

        // R5 ack clear with new ack in the same cycle
        cyc(1, 3'd3, 32'h1, 1, 3'd2, 32'h0000_0100);
        verify("R5 clear vs new ack");
        cyc(1, 3'd3, 32'h1, 0, 3'd0, 32'h0);
        verify("R5 ack clear");

        // R10 zero writes
        cyc(1, 3'd1, 32'h0000_0008, 1, 3'd4, 32'h0000_000F);
        cyc(1, 3'd1, 32'h0, 1, 3'd2, 32'h0);
        verify("R10 zero set and clear");
        cyc(1, 3'd3, 32'h0, 1, 3'd4, 32'h0);
        cyc(0, 3'd0, 32'h0, 1, 3'd5, 32'h0);
        verify("R10 zero mask writes");

        // R6 set wins over clear on the mask (two cycles to hit both regs not possible; check sequence)
        cyc(0, 3'd0, 32'h0, 1, 3'd5, 32'h0000_0008);
        verify("R6 mask clear unhides flag");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [2:0]  sa, ra;
            logic [31:0] sd, rd;
            logic        sw, rw;
            sw = ($urandom % 4) != 0;
            rw = ($urandom % 4) != 0;
            sa = 3'($urandom % 7);
            ra = 3'($urandom % 8);
            sd = ($urandom % 2) ? (32'h1 << ($urandom % 32)) : $urandom;
            rd = ($urandom % 3 == 0) ? $urandom : (m_flags & $urandom);
            if ($urandom % 5 == 0) begin
                sa = 3'd1; ra = 3'd2; sw = 1; rw = 1; rd = sd | m_flags;
            end
            cyc(sw, sa, sd, rw, ra, rd);
            if (i % 3 == 0) verify("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
        end
        verify("final");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule